// File: doc/BRIEF.md
# Oscillator Stabilization Wait Sequencer

This block keeps the chip's internal reset asserted, or holds back the return from stop mode, until the main oscillator has had time to settle. A time-base counter runs on the oscillator clock. It is cleared to zero when a wait starts, and the wait ends when the count first reaches the selected power of two. A power-on reset always waits a fixed, long interval. A reset taken in sub-clock mode, and a wake from stop mode, use a length picked by a 2-bit select input. The select input is latched when the wait starts.

The sequencer is a five-state machine. POR_WAIT is entered by the asynchronous power-on reset. RST_WAIT is entered from RUN, or from WAKE_WAIT, on a sub-clock reset request. WAKE_WAIT is entered from RUN on a stop-wake request. EXT_HOLD is entered from RUN when the synchronized external reset is asserted, or from a wait state that finishes while the external reset is still asserted. RUN is entered from a finished wait, or from EXT_HOLD, once the external reset is released. A trigger that arrives during any wait restarts that wait from zero. A sub-clock reset request that arrives during WAKE_WAIT turns it into RST_WAIT. The internal reset is released in WAKE_WAIT and RUN. The clock-ready flag is high only in RUN.

Top module: `osw_seq`

## Requirements
- R1: While `por_n` is low, `rst_int_n` and `clk_ready` are both low.
- R2: After `por_n` rises, `clk_ready` and `rst_int_n` rise on rising edge 2^EXP_POR + 1 after the release (default EXP_POR = 17). `wait_sel` has no effect on this wait.
- R3: A one-cycle `subclk_rst` pulse starts a reset wait. Its length depends on `wait_sel`: 00 gives 2^EXP_W0 (default 10), 01 gives 2^EXP_W1 (13), 10 gives 2^EXP_W2 (15) and 11 gives 2^EXP_W3 (18). The outputs rise on edge 2^E + 1 after the edge that sampled the pulse. During the wait, both outputs are low.
- R4: A `stop_wake` pulse in RUN starts a wait of the same selectable length. During this wait `clk_ready` is low and `rst_int_n` stays high.
- R5: `wait_sel` is sampled only on the edge that starts a wait. Changes to it during the wait do not alter the wait length.
- R6: A `stop_wake` or `subclk_rst` pulse during a wait restarts the count from zero, using the select value present with the new pulse. A `subclk_rst` pulse during a wake wait drives `rst_int_n` low.
- R7: If `ext_rst_n` is low when a reset wait ends, both outputs stay low until `ext_rst_n` is released. They then rise on the third rising edge after the release.
- R8: In RUN, `ext_rst_n` going low drives both outputs low on the third rising edge after the change. They stay low until the external reset is released.
- R9: After a reset-type wait, `clk_ready` and `rst_int_n` rise on the same edge. `clk_ready` is never high while `rst_int_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock, drives the time-base counter |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous (synchronized inside) |
| stop_wake | input | 1 | One-cycle request: wake from stop mode |
| subclk_rst | input | 1 | One-cycle request: reset taken in sub-clock mode |
| wait_sel | input | 2 | Wait-length select, sampled at wait start |
| rst_int_n | output | 1 | Internal reset, active low |
| clk_ready | output | 1 | Oscillator settled, clock usable |

## Verification
The hardest cases to reach from the ports are a wait that finishes while the external reset is still held, and a retrigger that lands in the middle of a running wait. In both, the release edge depends on two overlapping events and not on one pulse. The bench builds the instance with small exponents, so every wait length, including the power-on one, fits in a few hundred cycles. It drops `ext_rst_n` partway through a sub-clock reset wait and keeps it low past the wait's end. For retriggers, it fires a second request a fixed number of cycles after the first and replaces the expected release in its scoreboard, so a design that does not restart the count is reported.

// File: rtl/osw_pkg.sv
package osw_pkg;

    typedef enum logic [2:0] {
        S_POR_WAIT  = 3'd0,
        S_RST_WAIT  = 3'd1,
        S_WAKE_WAIT = 3'd2,
        S_EXT_HOLD  = 3'd3,
        S_RUN       = 3'd4
    } osw_state_e;

    function automatic logic is_wait_state(input osw_state_e s);
        return (s == S_POR_WAIT) || (s == S_RST_WAIT) || (s == S_WAKE_WAIT);
    endfunction

endpackage

// File: rtl/osw_timebase.sv
module osw_timebase #(
    parameter int CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    // Free-running count of oscillator cycles, zeroed at each wait start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/osw_sync.sv
module osw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Resets to 0 so the external reset reads as asserted until proven released.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/osw_tap.sv
module osw_tap #(
    parameter int CNT_W   = 19,
    parameter int EXP_W0  = 10,
    parameter int EXP_W1  = 13,
    parameter int EXP_W2  = 15,
    parameter int EXP_W3  = 18,
    parameter int EXP_POR = 17
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [1:0]       sel_q,
    input  logic             use_por,
    output logic             done
);

    localparam int EXPS [4] = '{EXP_W0, EXP_W1, EXP_W2, EXP_W3};

    logic [3:0] sel_hit;
    logic       por_hit;

    // Count has reached 2^e: first true exactly at 2^e after a clear.
    generate
        for (genvar g = 0; g < 4; g++) begin : g_tap
            assign sel_hit[g] = (cnt >> EXPS[g]) != '0;
        end
    endgenerate

    assign por_hit = (cnt >> EXP_POR) != '0;
    assign done    = use_por ? por_hit : sel_hit[sel_q];

endmodule

// File: rtl/osw_fsm.sv
module osw_fsm
    import osw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_wake,
    input  logic       subclk_rst,
    input  logic [1:0] wait_sel,
    input  logic       ext_ok,
    input  logic       done,
    output logic       tb_clr,
    output logic [1:0] sel_q,
    output logic       use_por,
    output logic       in_wait,
    output logic       rst_int_n,
    output logic       clk_ready
);

    osw_state_e state, nxt;
    logic       load;
    logic       trig;

    assign trig = stop_wake | subclk_rst;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_POR_WAIT;
        end else begin
            state <= nxt;
        end
    end

    // Latched wait select, resets to the longest setting.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 2'b11;
        end else if (load) begin
            sel_q <= wait_sel;
        end
    end

    // Transitions.
    always_comb begin
        nxt    = state;
        tb_clr = 1'b0;
        load   = 1'b0;
        unique case (state)
            S_POR_WAIT: begin
                if (trig) begin
                    tb_clr = 1'b1;
                end else if (done) begin
                    nxt = ext_ok ? S_RUN : S_EXT_HOLD;
                end
            end
            S_RST_WAIT: begin
                if (trig) begin
                    tb_clr = 1'b1;
                    load   = 1'b1;
                end else if (done) begin
                    nxt = ext_ok ? S_RUN : S_EXT_HOLD;
                end
            end
            S_WAKE_WAIT: begin
                if (subclk_rst) begin
                    nxt    = S_RST_WAIT;
                    tb_clr = 1'b1;
                    load   = 1'b1;
                end else if (stop_wake) begin
                    tb_clr = 1'b1;
                    load   = 1'b1;
                end else if (done) begin
                    nxt = ext_ok ? S_RUN : S_EXT_HOLD;
                end
            end
            S_EXT_HOLD: begin
                if (ext_ok) begin
                    nxt = S_RUN;
                end
            end
            S_RUN: begin
                if (!ext_ok) begin
                    nxt = S_EXT_HOLD;
                end else if (subclk_rst) begin
                    nxt    = S_RST_WAIT;
                    tb_clr = 1'b1;
                    load   = 1'b1;
                end else if (stop_wake) begin
                    nxt    = S_WAKE_WAIT;
                    tb_clr = 1'b1;
                    load   = 1'b1;
                end
            end
            default: begin
                nxt = S_POR_WAIT;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        use_por   = (state == S_POR_WAIT);
        in_wait   = is_wait_state(state);
        rst_int_n = (state == S_RUN) || (state == S_WAKE_WAIT);
        clk_ready = (state == S_RUN);
    end

    // A wait whose tap has not been reached never releases the clock.
    assert_no_early_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && !done) |=> !clk_ready);

    // A wait whose tap is reached with the external reset released goes to RUN.
    assert_release_on_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && done && !trig && ext_ok) |=> clk_ready);

    // Select stays fixed for the length of a wait unless retriggered.
    assert_sel_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && !trig) |=> $stable(sel_q));

    // External reset seen asserted keeps the clock not-ready next cycle.
    assert_ext_blocks_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_ok |=> !clk_ready);

    // Ready never without reset released.
    assert_ready_needs_rst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_ready) |-> rst_int_n);

endmodule

// File: rtl/osw_seq.sv
module osw_seq #(
    parameter int EXP_W0  = 10,
    parameter int EXP_W1  = 13,
    parameter int EXP_W2  = 15,
    parameter int EXP_W3  = 18,
    parameter int EXP_POR = 17
) (
    input  logic       clk_osc,
    input  logic       por_n,
    input  logic       ext_rst_n,
    input  logic       stop_wake,
    input  logic       subclk_rst,
    input  logic [1:0] wait_sel,
    output logic       rst_int_n,
    output logic       clk_ready
);

    localparam int MAX_A   = (EXP_W0 > EXP_W1) ? EXP_W0 : EXP_W1;
    localparam int MAX_B   = (EXP_W2 > EXP_W3) ? EXP_W2 : EXP_W3;
    localparam int MAX_S   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int EXP_MAX = (MAX_S > EXP_POR) ? MAX_S : EXP_POR;
    localparam int CNT_W   = EXP_MAX + 1;

    logic [CNT_W-1:0] tb_cnt;
    logic             tb_clr;
    logic             ext_ok;
    logic             done;
    logic [1:0]       sel_q;
    logic             use_por;
    logic             in_wait;

    osw_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk   (clk_osc),
        .rst_n (por_n),
        .clr   (tb_clr),
        .cnt   (tb_cnt)
    );

    osw_sync #(.STAGES(2)) u_ext_sync (
        .clk   (clk_osc),
        .rst_n (por_n),
        .d     (ext_rst_n),
        .q     (ext_ok)
    );

    osw_tap #(
        .CNT_W   (CNT_W),
        .EXP_W0  (EXP_W0),
        .EXP_W1  (EXP_W1),
        .EXP_W2  (EXP_W2),
        .EXP_W3  (EXP_W3),
        .EXP_POR (EXP_POR)
    ) u_tap (
        .cnt     (tb_cnt),
        .sel_q   (sel_q),
        .use_por (use_por),
        .done    (done)
    );

    osw_fsm u_fsm (
        .clk        (clk_osc),
        .rst_n      (por_n),
        .stop_wake  (stop_wake),
        .subclk_rst (subclk_rst),
        .wait_sel   (wait_sel),
        .ext_ok     (ext_ok),
        .done       (done),
        .tb_clr     (tb_clr),
        .sel_q      (sel_q),
        .use_por    (use_por),
        .in_wait    (in_wait),
        .rst_int_n  (rst_int_n),
        .clk_ready  (clk_ready)
    );

    // A trigger during a wait zeroes the time base on the next edge.
    assert_restart_zero_R6: assert property (@(posedge clk_osc) disable iff (!por_n)
        (in_wait && (stop_wake || subclk_rst)) |=> (tb_cnt == '0));

endmodule

// File: tb/tb_osw_seq.sv
module tb_osw_seq;

    localparam int CLK_PERIOD = 10;
    localparam int E0 = 4;
    localparam int E1 = 5;
    localparam int E2 = 6;
    localparam int E3 = 7;
    localparam int EP = 8;
    localparam int WATCHDOG = 100000;

    typedef struct {
        int    due;
        bit    rst_type;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       stop_wake = 1'b0;
    logic       subclk_rst = 1'b0;
    logic [1:0] wait_sel = 2'b00;
    logic       rst_int_n;
    logic       clk_ready;

    int   cyc = 0;
    int   n_tests = 0;
    int   n_fail = 0;
    exp_t sb[$];
    exp_t item;
    logic prev_ready = 1'b0;
    logic prev_rst = 1'b0;

    osw_seq #(
        .EXP_W0(E0), .EXP_W1(E1), .EXP_W2(E2), .EXP_W3(E3), .EXP_POR(EP)
    ) dut (
        .clk_osc    (clk),
        .por_n      (por_n),
        .ext_rst_n  (ext_rst_n),
        .stop_wake  (stop_wake),
        .subclk_rst (subclk_rst),
        .wait_sel   (wait_sel),
        .rst_int_n  (rst_int_n),
        .clk_ready  (clk_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int sel_len(input logic [1:0] s);
        case (s)
            2'b00:   return 1 << E0;
            2'b01:   return 1 << E1;
            2'b10:   return 1 << E2;
            default: return 1 << E3;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic go_to(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Driver: fire a one-cycle request and push the expected release.
    task automatic fire(input bit is_sub, input logic [1:0] sel,
                        input bit replace, input string tag);
        exp_t e;
        @(negedge clk);
        wait_sel   = sel;
        stop_wake  = !is_sub;
        subclk_rst = is_sub;
        if (replace && sb.size() != 0) void'(sb.pop_back());
        e.due      = cyc + sel_len(sel) + 2;
        e.rst_type = is_sub;
        e.tag      = tag;
        sb.push_back(e);
        @(negedge clk);
        stop_wake  = 1'b0;
        subclk_rst = 1'b0;
    endtask

    // Monitor: compare each rise of clk_ready against the scoreboard.
    always @(negedge clk) begin
        if (por_n && clk_ready && !prev_ready) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R9", "unexpected clk_ready rise at cycle", cyc, -1);
            end else begin
                item = sb.pop_front();
                chk(cyc == item.due, item.tag, "release cycle", cyc, item.due);
                chk(rst_int_n == 1'b1, "R9", "rst_int_n at ready rise", int'(rst_int_n), 1);
                if (item.rst_type)
                    chk(prev_rst == 1'b0, "R9", "rst_int_n before rise", int'(prev_rst), 0);
            end
        end
        prev_ready = clk_ready;
        prev_rst   = rst_int_n;
    end

    initial begin
        while (cyc < WATCHDOG) @(negedge clk);
        chk(1'b0, "WDOG", "watchdog expired at cycle", cyc, WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        exp_t e;
        int   c;

        // R1: outputs low during power-on reset
        repeat (3) @(negedge clk);
        chk(rst_int_n == 1'b0, "R1", "rst_int_n in POR", int'(rst_int_n), 0);
        chk(clk_ready == 1'b0, "R1", "clk_ready in POR", int'(clk_ready), 0);

        // R2: fixed power-on wait, select ignored
        wait_sel = 2'b00;
        e.due = cyc + (1 << EP) + 1;
        e.rst_type = 1'b1;
        e.tag = "R2";
        sb.push_back(e);
        por_n = 1'b1;
        drain();

        // R3: all four select codes on sub-clock reset
        for (int s = 0; s < 4; s++) begin
            fire(1'b1, 2'(s), 1'b0, "R3");
            @(negedge clk);
            chk(rst_int_n == 1'b0, "R3", "rst_int_n during reset wait", int'(rst_int_n), 0);
            chk(clk_ready == 1'b0, "R3", "clk_ready during reset wait", int'(clk_ready), 0);
            drain();
        end

        // R4: stop wake keeps reset released
        fire(1'b0, 2'b10, 1'b0, "R4");
        @(negedge clk);
        chk(rst_int_n == 1'b1, "R4", "rst_int_n during wake wait", int'(rst_int_n), 1);
        chk(clk_ready == 1'b0, "R4", "clk_ready during wake wait", int'(clk_ready), 0);
        drain();

        // R5: select change during a wait is ignored
        fire(1'b1, 2'b00, 1'b0, "R5");
        wait_sel = 2'b11;
        drain();

        // R6: retrigger restarts the count
        fire(1'b0, 2'b01, 1'b0, "R6");
        repeat (10) @(negedge clk);
        fire(1'b0, 2'b00, 1'b1, "R6");
        drain();

        // R6: sub-clock reset during a wake wait becomes a reset wait
        fire(1'b0, 2'b10, 1'b0, "R6");
        repeat (5) @(negedge clk);
        fire(1'b1, 2'b00, 1'b1, "R6");
        chk(rst_int_n == 1'b0, "R6", "rst_int_n after sub reset in wake", int'(rst_int_n), 0);
        drain();

        // R7: wait ends while external reset held
        fire(1'b1, 2'b00, 1'b0, "R7");
        e = sb.pop_back();
        ext_rst_n = 1'b0;
        go_to(e.due + 5);
        chk(rst_int_n == 1'b0, "R7", "rst_int_n held by ext reset", int'(rst_int_n), 0);
        chk(clk_ready == 1'b0, "R7", "clk_ready held by ext reset", int'(clk_ready), 0);
        e.due = cyc + 3;
        e.rst_type = 1'b1;
        e.tag = "R7";
        sb.push_back(e);
        ext_rst_n = 1'b1;
        drain();

        // R8: external reset while running
        c = cyc;
        ext_rst_n = 1'b0;
        go_to(c + 2);
        chk(rst_int_n == 1'b1, "R8", "rst_int_n before sync delay", int'(rst_int_n), 1);
        go_to(c + 3);
        chk(rst_int_n == 1'b0, "R8", "rst_int_n after ext assert", int'(rst_int_n), 0);
        chk(clk_ready == 1'b0, "R8", "clk_ready after ext assert", int'(clk_ready), 0);
        repeat (20) @(negedge clk);
        chk(rst_int_n == 1'b0, "R8", "rst_int_n held", int'(rst_int_n), 0);
        e.due = cyc + 3;
        e.rst_type = 1'b1;
        e.tag = "R8";
        sb.push_back(e);
        ext_rst_n = 1'b1;
        drain();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule